// File: doc/BRIEF.md
# Byte-Lane RAM with Address Hold

A single-clock, single-port synchronous RAM whose 16-bit word is split into two 8-bit lanes that can be written independently. All inputs are captured in an input register stage on the rising clock edge. The memory operation then takes place on the following edge, and that same edge loads a registered read-data output. The read address sits behind a hold multiplexer. While the stall input is high, the multiplexer feeds the address register's own output back into it, so the captured address stays frozen while data, enables and lane mask continue to be sampled.

Each write updates only the lanes whose enable bit is set. A lane whose enable bit is clear keeps its stored byte and shows that stored byte on the output. A lane whose enable bit is set shows either the freshly written byte or the byte it held before the write. A build-time mode parameter picks between the two. The memory array has no reset and starts with undefined contents. The reset clears only the address register, the input stage and the output register.

Top module: `byte_lane_ram`

## Requirements
- R1: On a write, a lane whose lane_en bit is 0 keeps its stored byte, and rdata shows that stored byte in that lane.
- R2: On a write, a lane whose lane_en bit is 1 stores the new byte. rdata shows the new byte in that lane when RDW_MODE is RDW_NEW (1), and the byte stored before the write when RDW_MODE is RDW_OLD (0).
- R3: lane_en[1] governs bits 15:8 and lane_en[0] governs bits 7:0. Writing 0xABCD over 0xFFFF leaves 0xABFF with lane_en=2'b10, 0xFFCD with 2'b01, and 0xABCD with 2'b11.
- R4: While addr_stall is 1 at a rising edge, the address register keeps its value and addr_in is ignored.
- R5: addr_stall holds only the address. wdata, wr_en, rd_en and lane_en are still captured at that edge, so a write issued during a stall lands at the held address.
- R6: A read (rd_en=1, wr_en=0) presented before edge k returns the full stored word at the registered address on rdata after edge k+1.
- R7: When the captured operation has wr_en=0 and rd_en=0, rdata keeps its previous value.
- R8: Reset (rst_n=0, asynchronous) clears rdata to 0 and the address register to 0. Memory contents are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | Word address |
| wdata | input | 16 | Write data, two 8-bit lanes |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| lane_en | input | 2 | Per-lane write mask, bit 1 = upper byte |
| addr_stall | input | 1 | Hold the registered address while high |
| rdata | output | 16 | Registered read data |

## Verification
The bench builds two copies side by side with the default ADDR_W of 9: one with RDW_MODE set to new-data and one set to old-data. Both receive identical stimulus, so every write shows the two read-during-write rules against the same memory state. With the full 512-word depth, every location is written before random traffic starts. Half the random addresses are drawn from a 16-word window, so back-to-back writes and reads to the same word are common. Stall bursts land on reads and writes alike.

// File: rtl/byte_ram_pkg.sv
package byte_ram_pkg;

  typedef enum logic {
    RDW_OLD = 1'b0,
    RDW_NEW = 1'b1
  } rdw_mode_e;

  // An operation touches the array when either request is set.
  function automatic logic is_access(input logic wr, input logic rd);
    return wr | rd;
  endfunction

  // A lane stores new data only when a write is requested and its mask bit is set.
  function automatic logic lane_writes(input logic wr, input logic mask_bit);
    return wr & mask_bit;
  endfunction

  // Byte seen on the output of one lane for an accessing operation.
  function automatic logic [7:0] lane_out(input logic wr_lane, input rdw_mode_e mode,
                                          input logic [7:0] new_b, input logic [7:0] old_b);
    return (wr_lane && mode == RDW_NEW) ? new_b : old_b;
  endfunction

endpackage

// File: rtl/bram_addr_hold.sv
module bram_addr_hold #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] addr_nxt;
  logic              hold_evt;

  assign hold_evt = stall;
  // Feedback multiplexer: stall selects the register's own output.
  assign addr_nxt = hold_evt ? addr_q : addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_nxt;
  end

  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(addr_q));

  p_free_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> addr_q == $past(addr_in));

endmodule

// File: rtl/bram_ctrl_stage.sv
module bram_ctrl_stage
  import byte_ram_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc_q,
  output logic [LANES-1:0]  wr_lane_q,
  output logic [DATA_W-1:0] wdata_q
);

  logic [LANES-1:0] wr_lane_nxt;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign wr_lane_nxt[g] = lane_writes(wr_en, lane_en[g]);
  end

  // Captured every cycle; addr_stall does not reach this stage (R5).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      wr_lane_q <= '0;
      wdata_q   <= '0;
    end else begin
      acc_q     <= is_access(wr_en, rd_en);
      wr_lane_q <= wr_lane_nxt;
      wdata_q   <= wdata;
    end
  end

  p_write_implies_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_lane_q) |-> acc_q);

endmodule

// File: rtl/bram_lane.sv
module bram_lane
  import byte_ram_pkg::*;
#(
  parameter int        ADDR_W   = 9,
  parameter int        LANE_W   = 8,
  parameter rdw_mode_e RDW_MODE = RDW_NEW,
  localparam int       DEPTH    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc,
  input  logic              wr,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] cur_byte;
  logic [LANE_W-1:0] sel_byte;

  assign cur_byte = mem[addr];
  assign sel_byte = (wr && RDW_MODE == RDW_NEW) ? din : cur_byte;

  // Array has no reset: contents are undefined until written.
  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout <= '0;
    else if (acc) dout <= sel_byte;
  end

  // Masked lane or plain read: output shows the byte stored before the edge.
  p_masked_old_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wr) |=> dout == $past(cur_byte));

  p_write_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> dout == ((RDW_MODE == RDW_NEW) ? $past(din) : $past(cur_byte)));

  p_write_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && $past(addr) == addr && $past(wr)) |-> cur_byte == $past(din));

endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram
  import byte_ram_pkg::*;
#(
  parameter int        ADDR_W   = 9,
  parameter rdw_mode_e RDW_MODE = RDW_NEW,
  localparam int       LANES    = 2,
  localparam int       LANE_W   = 8,
  localparam int       DATA_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic              addr_stall,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic              acc_q;
  logic [LANES-1:0]  wr_lane_q;
  logic [DATA_W-1:0] wdata_q;

  bram_addr_hold #(.ADDR_W(ADDR_W)) i_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (addr_stall),
    .addr_in (addr_in),
    .addr_q  (addr_q)
  );

  bram_ctrl_stage #(.LANES(LANES), .LANE_W(LANE_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .lane_en   (lane_en),
    .wdata     (wdata),
    .acc_q     (acc_q),
    .wr_lane_q (wr_lane_q),
    .wdata_q   (wdata_q)
  );

  // Lane g occupies bits [g*LANE_W +: LANE_W]; lane_en[1] is the upper byte (R3).
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .RDW_MODE(RDW_MODE)) i_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .addr (addr_q),
      .acc  (acc_q),
      .wr   (wr_lane_q[g]),
      .din  (wdata_q[g*LANE_W +: LANE_W]),
      .dout (rdata[g*LANE_W +: LANE_W])
    );
  end

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_q |=> $stable(rdata));

  p_stall_no_write_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stall && wr_en) |=> (|wr_lane_q) == $past(|lane_en));

endmodule

// File: tb/test_byte_lane_ram.sv
`timescale 1ns/1ps
module test_byte_lane_ram;
  import byte_ram_pkg::*;

  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [15:0]   wdata = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0, addr_stall = 1'b0;
  logic [1:0]    lane_en = '0;
  logic [15:0]   rdata_new, rdata_old;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  byte_lane_ram #(.ADDR_W(AW), .RDW_MODE(RDW_NEW)) i_byte_lane_ram (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .lane_en(lane_en), .addr_stall(addr_stall), .rdata(rdata_new));

  byte_lane_ram #(.ADDR_W(AW), .RDW_MODE(RDW_OLD)) i_byte_lane_ram_old (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .lane_en(lane_en), .addr_stall(addr_stall), .rdata(rdata_old));

  // Reference model
  logic [15:0]   mmem [DEPTH];
  logic [1:0]    mval [DEPTH];
  logic [AW-1:0] maddr;
  logic          mwe, mre, mheld;
  logic [1:0]    mbe;
  logic [15:0]   md;
  logic [15:0]   exp_new, exp_old;
  logic [1:0]    kn_new, kn_old;
  string         cur_tag;

  function automatic logic [15:0] lane_mask(input logic [1:0] kn);
    return {{8{kn[1]}}, {8{kn[0]}}};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    maddr = '0; mwe = 0; mre = 0; mheld = 0; mbe = '0; md = '0;
    exp_new = '0; exp_old = '0; kn_new = 2'b11; kn_old = 2'b11;
  endtask

  task automatic model_edge(input logic [AW-1:0] a, input logic [15:0] d, input logic we,
                            input logic re, input logic [1:0] be, input logic st);
    if (!(mwe | mre)) cur_tag = "R7 idle hold";
    else if (mwe)     cur_tag = mheld ? "R5 write at held address" : "R1/R2 write lanes";
    else              cur_tag = mheld ? "R4 stalled read" : "R6 read";
    if (mwe | mre) begin
      for (int l = 0; l < 2; l++) begin
        logic [7:0] ob, nb;
        logic       wl;
        ob = mmem[maddr][l*8 +: 8];
        nb = md[l*8 +: 8];
        wl = mwe & mbe[l];
        exp_new[l*8 +: 8] = wl ? nb : ob;
        exp_old[l*8 +: 8] = ob;
        kn_new[l] = wl | mval[maddr][l];
        kn_old[l] = mval[maddr][l];
        if (wl) begin
          mmem[maddr][l*8 +: 8] = nb;
          mval[maddr][l] = 1'b1;
        end
      end
    end
    if (!st) maddr = a;
    mwe = we; mre = re; mbe = be; md = d; mheld = st;
  endtask

  // Called at a negedge; returns at the next negedge after comparing.
  task automatic step(input logic [AW-1:0] a, input logic [15:0] d, input logic we,
                      input logic re, input logic [1:0] be, input logic st);
    addr_in = a; wdata = d; wr_en = we; rd_en = re; lane_en = be; addr_stall = st;
    @(posedge clk);
    model_edge(a, d, we, re, be, st);
    @(negedge clk);
    if (kn_new != 0) chk({cur_tag, " new-mode"}, rdata_new & lane_mask(kn_new), exp_new & lane_mask(kn_new));
    if (kn_old != 0) chk({cur_tag, " old-mode"}, rdata_old & lane_mask(kn_old), exp_old & lane_mask(kn_old));
  endtask

  task automatic r3_case(input logic [1:0] be, input logic [15:0] expv);
    step(5, 16'hFFFF, 1, 0, 2'b11, 0);
    step(5, 16'hABCD, 1, 0, be, 0);
    step(5, 16'h0000, 0, 1, 2'b00, 0);
    step(5, 16'h0000, 0, 0, 2'b00, 0);
    chk("R3 lane order new-mode", rdata_new, expv);
    chk("R3 lane order old-mode", rdata_old, expv);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mval[i] = 2'b00;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R8 reset rdata new-mode", rdata_new, 16'h0000);
    chk("R8 reset rdata old-mode", rdata_old, 16'h0000);

    for (int a = 0; a < DEPTH; a++) step(a[AW-1:0], 16'($urandom), 1, 0, 2'b11, 0);
    step(0, 0, 0, 0, 2'b00, 0);

    r3_case(2'b10, 16'hABFF);
    r3_case(2'b01, 16'hFFCD);
    r3_case(2'b11, 16'hABCD);

    // Stall burst: address 9 held while addr_in wanders; a write lands at 9.
    step(9, 0, 0, 1, 2'b00, 0);
    for (int i = 0; i < 4; i++) step(AW'($urandom), 16'($urandom), 0, 1, 2'b00, 1);
    step(AW'($urandom), 16'h1234, 1, 0, 2'b11, 1);
    step(AW'($urandom), 0, 0, 1, 2'b00, 1);
    step(0, 0, 0, 0, 2'b00, 0);
    chk("R5 write during stall lands at held address", rdata_new, 16'h1234);
    chk("R4 held address read back", rdata_old, mmem[9]);

    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 2 == 0) ? AW'($urandom % 16) : AW'($urandom);
      step(a, 16'($urandom), ($urandom % 3) == 0, ($urandom % 3) != 0,
           2'($urandom), ($urandom % 4) == 0);
    end

    // Second reset mid-run: registers clear, memory survives.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk("R8 reset rdata again", rdata_new, 16'h0000);
    step(77, 0, 0, 1, 2'b00, 1);
    step(0, 0, 0, 0, 2'b00, 0);
    chk("R8 address register cleared to 0", rdata_new, mmem[0]);
    chk("R8 memory kept across reset", rdata_old, mmem[0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule